// File: doc/BRIEF.md
# I2C Address Match and Transfer Direction Tracker

This block runs beside the shift engine of an I2C interface and follows the bus from sampled SCL and SDA. It finds start and stop conditions, counts SCL clocks in each byte, and picks up the seven address bits and the read/write bit of the first byte after a start. From these it keeps two status flags. The address-match flag says that this node was selected as a slave. The direction flag says whether the node is now transmitting or receiving.

Both flags follow exact set and clear rules that differ for master and slave roles. The block also gives an SDA drive enable for the transmit latch, and an SCL hold request that stretches the bus after the ninth (acknowledge) clock. Software ends that hold either by writing the shift register or by strobing a wait-release input. A wait-release strobe also drops the direction flag, so SDA goes back to high impedance.

Top module: `i2c_addr_dir_tracker`

## Requirements
- R1: Start is SDA going 1 to 0 while SCL stays high, and stop is SDA going 0 to 1 while SCL stays high. Both inputs pass a two-flop synchronizer, so a bus change reaches the flags on the third system clock edge. SCL rising edges are counted 1 to 9 in each byte, and a start sets the count back to zero.
- R2: The address-match flag is 0 after reset, and it clears on a detected start or a detected stop.
- R3: When not master, the address-match flag sets at the 8th SCL rising edge of the first byte after a start. It sets if the seven bits sampled on rising edges 1 to 7 (MSB first) equal `localAddr`. As master it never sets.
- R4: As slave, at the 8th rising edge the direction flag takes the sampled LSB (1 means transmit, 0 means receive). A detected start clears it.
- R5: As master, a `startGen` pulse sets the direction flag. At the 8th rising edge the flag becomes the inverse of the LSB on the bus (0 means write, so transmit).
- R6: `exitReq` clears both flags. A stop or a rising edge of `arbLost` clears the direction flag.
- R7: While `enable` is 0, both flags and `sclHold` are 0 and no bus activity sets them.
- R8: A `waitRelease` pulse clears the direction flag and `sclHold` on the next clock.
- R9: `sdaDriveEn` is 1 only in transmit state. For a slave it also needs the ninth-clock falling edge of the first byte to have passed since the last start. A master drives from the moment it is in transmit state.
- R10: `sclHold` rises after the falling edge of a ninth clock while the node is communicating. It stays up until `shiftWrite` or `waitRelease` is pulsed, and it drops on the clock after that pulse.
- R11: The direction flag is 0 whenever the node is not master, `extComm` is 0 and no address match is held. With `extComm` high, a slave takes the direction even without an address match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL line sample |
| sdaIn | input | 1 | Raw SDA line sample |
| enable | input | 1 | Interface enable; 0 holds everything cleared |
| isMaster | input | 1 | Node is acting as bus master |
| extComm | input | 1 | Extended-code communication in progress |
| localAddr | input | 7 | Own slave address |
| startGen | input | 1 | Pulse: master has generated a start |
| exitReq | input | 1 | Pulse: leave the current communication |
| waitRelease | input | 1 | Pulse: cancel the ninth-clock wait |
| arbLost | input | 1 | Arbitration-lost flag (its rising edge acts) |
| shiftWrite | input | 1 | Pulse: shift register written |
| addrMatch | output | 1 | Address-match flag |
| txState | output | 1 | Direction flag, 1 = transmit |
| sdaDriveEn | output | 1 | Enables the SDA output latch onto the bus |
| sclHold | output | 1 | Request to hold SCL low (wait) |

## Verification
On every cycle the assertions check these rules: start and stop clear the match flag, the match flag rises only on an address-completion clock, a disabled interface holds all state clear, a wait-release strobe drops both direction and hold, and a hold starts only after a ninth-clock falling edge. Some rules can only be shown by the bench's scenarios, where a per-clock reference model follows bus sequences. These are the cross-role direction rules (master write and read, a slave addressed for read or write, a mismatched address with and without extended communication), the slave drive window that opens at the first acknowledge, and a repeated start that cuts a partial byte short.

// File: rtl/i2c_trk_pkg.sv
package i2c_trk_pkg;

  // Bus events decoded by the datapath, consumed by the control.
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic addrDone;        // 8th rising SCL edge of the first byte
    logic lsb;             // SDA value at that edge
    logic addrEq;          // collected address equals the local address
    logic ninthFall;       // falling SCL edge that ends clock 9
    logic firstNinthFall;  // same, for the first byte after a start
  } busEvt_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic flush;           // abandon byte tracking until the next start
  } dpCtl_t;

endpackage

// File: rtl/i2c_trk_datapath.sv
module i2c_trk_datapath
  import i2c_trk_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] localAddr,
  input  dpCtl_t            ctl,
  output busEvt_t           evt
);

  localparam int CNT_W = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclCur, sdaCur;
  logic [CNT_W-1:0]  bitCnt;
  logic              firstByte;
  logic [ADDR_W-1:0] addrShift;

  // Synchronizers reset to the idle (high) bus level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclCur = sclPipe[SYNC_STAGES-1];
  assign sdaCur = sdaPipe[SYNC_STAGES-1];

  logic sclFall;
  always_comb begin
    evt.start   = sclPrev && sclCur && sdaPrev && !sdaCur;
    evt.stop    = sclPrev && sclCur && !sdaPrev && sdaCur;
    evt.sclRise = !sclPrev && sclCur;
    sclFall     = sclPrev && !sclCur;
    evt.addrDone       = evt.sclRise && firstByte && (bitCnt == ADDR_LAST);
    evt.lsb            = sdaCur;
    evt.addrEq         = (addrShift == localAddr);
    evt.ninthFall      = sclFall && (bitCnt == ACK_SLOT);
    evt.firstNinthFall = evt.ninthFall && firstByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      firstByte <= 1'b0;
      addrShift <= '0;
    end else if (ctl.flush || evt.stop) begin
      bitCnt    <= '0;
      firstByte <= 1'b0;
    end else if (evt.start) begin
      bitCnt    <= '0;
      firstByte <= 1'b1;
      addrShift <= '0;
    end else if (evt.sclRise) begin
      bitCnt <= (bitCnt == ACK_SLOT) ? CNT_ONE : bitCnt + CNT_ONE;
      if (firstByte && (bitCnt < ADDR_LAST))
        addrShift <= {addrShift[ADDR_W-2:0], sdaCur};
    end else if (evt.firstNinthFall) begin
      firstByte <= 1'b0;
    end
  end

  // R1: every counted rising edge leaves a non-zero clock count
  a_r1_count_advances: assert property (@(posedge clk) disable iff (!rstN)
    (evt.sclRise && !ctl.flush) |=> (bitCnt != '0));

  // R1: a start always brings the count back to zero
  a_r1_start_clears_count: assert property (@(posedge clk) disable iff (!rstN)
    (evt.start && !ctl.flush) |=> (bitCnt == '0) && firstByte);

endmodule

// File: rtl/i2c_trk_control.sv
module i2c_trk_control
  import i2c_trk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t evt,
  input  logic    enable,
  input  logic    isMaster,
  input  logic    extComm,
  input  logic    startGen,
  input  logic    exitReq,
  input  logic    waitRelease,
  input  logic    arbLost,
  input  logic    shiftWrite,
  output dpCtl_t  ctl,
  output logic    addrMatch,
  output logic    txState,
  output logic    sdaDriveEn,
  output logic    sclHold
);

  logic arbPrev, pastFirst;
  logic kill, arbRise, inComm;
  logic matchNext, txNext, pastNext, holdNext;

  always_comb begin
    kill    = !enable || evt.stop || exitReq;
    arbRise = arbLost && !arbPrev;
    ctl.flush = !enable || exitReq;

    matchNext = addrMatch;
    if (kill || evt.start)
      matchNext = 1'b0;
    else if (evt.addrDone && !isMaster && evt.addrEq)
      matchNext = 1'b1;

    inComm = isMaster || extComm || matchNext;

    txNext = txState;
    if (kill || waitRelease || arbRise || !inComm)
      txNext = 1'b0;
    else if (isMaster) begin
      if (startGen)          txNext = 1'b1;
      else if (evt.addrDone) txNext = !evt.lsb;
    end else begin
      if (evt.start)         txNext = 1'b0;
      else if (evt.addrDone) txNext = evt.lsb;
    end

    pastNext = pastFirst;
    if (kill || evt.start)         pastNext = 1'b0;
    else if (evt.firstNinthFall)   pastNext = 1'b1;

    holdNext = sclHold;
    if (kill || evt.start || waitRelease || shiftWrite)
      holdNext = 1'b0;
    else if (evt.ninthFall && inComm)
      holdNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrMatch <= 1'b0;
      txState   <= 1'b0;
      pastFirst <= 1'b0;
      sclHold   <= 1'b0;
      arbPrev   <= 1'b0;
    end else begin
      addrMatch <= matchNext;
      txState   <= txNext;
      pastFirst <= pastNext;
      sclHold   <= holdNext;
      arbPrev   <= arbLost;
    end
  end

  assign sdaDriveEn = txState && (isMaster || pastFirst);

  // R2: start or stop on the bus leaves no match
  a_r2_bus_event_clears_match: assert property (@(posedge clk) disable iff (!rstN)
    (evt.start || evt.stop) |=> !addrMatch);

  // R3: the match flag only rises on an address-completion clock
  a_r3_match_on_addr_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrMatch) |-> $past(evt.addrDone));

  // R7: a disabled interface keeps all state clear
  a_r7_disabled_clear: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!addrMatch && !txState && !sclHold));

  // R8: a wait-release strobe drops direction and hold
  a_r8_release_drops: assert property (@(posedge clk) disable iff (!rstN)
    waitRelease |=> (!txState && !sclHold));

  // R6: exit strobe clears both flags
  a_r6_exit_clears: assert property (@(posedge clk) disable iff (!rstN)
    exitReq |=> (!txState && !addrMatch));

  // R10: a hold starts only after a ninth-clock falling edge
  a_r10_hold_after_ninth: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclHold) |-> $past(evt.ninthFall));

endmodule

// File: rtl/i2c_addr_dir_tracker.sv
module i2c_addr_dir_tracker
  import i2c_trk_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              enable,
  input  logic              isMaster,
  input  logic              extComm,
  input  logic [ADDR_W-1:0] localAddr,
  input  logic              startGen,
  input  logic              exitReq,
  input  logic              waitRelease,
  input  logic              arbLost,
  input  logic              shiftWrite,
  output logic              addrMatch,
  output logic              txState,
  output logic              sdaDriveEn,
  output logic              sclHold
);

  busEvt_t evt;
  dpCtl_t  ctl;

  i2c_trk_datapath #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .BYTE_BITS(BYTE_BITS)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .localAddr(localAddr), .ctl(ctl), .evt(evt)
  );

  i2c_trk_control u_control (
    .clk(clk), .rstN(rstN), .evt(evt), .enable(enable),
    .isMaster(isMaster), .extComm(extComm), .startGen(startGen),
    .exitReq(exitReq), .waitRelease(waitRelease), .arbLost(arbLost),
    .shiftWrite(shiftWrite), .ctl(ctl), .addrMatch(addrMatch),
    .txState(txState), .sdaDriveEn(sdaDriveEn), .sclHold(sclHold)
  );

endmodule

// File: tb/test_i2c_addr_dir_tracker.sv
module test_i2c_addr_dir_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic enable = 1'b0, isMaster = 1'b0, extComm = 1'b0;
  logic [ADDR_W-1:0] localAddr = 7'h5A;
  logic startGen = 1'b0, exitReq = 1'b0, waitRelease = 1'b0;
  logic arbLost = 1'b0, shiftWrite = 1'b0;
  logic addrMatch, txState, sdaDriveEn, sclHold;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_dir_tracker i_i2c_addr_dir_tracker (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda), .enable(enable),
    .isMaster(isMaster), .extComm(extComm), .localAddr(localAddr),
    .startGen(startGen), .exitReq(exitReq), .waitRelease(waitRelease),
    .arbLost(arbLost), .shiftWrite(shiftWrite), .addrMatch(addrMatch),
    .txState(txState), .sdaDriveEn(sdaDriveEn), .sclHold(sclHold)
  );

  task automatic chk(input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [1:0] hist[$];
  int  mCnt, mAddr;
  bit  mFirst, mMatch, mTx, mPast, mHold, mArbPrev;

  always @(posedge clk) begin
    if (!rstN) begin
      hist = '{2'b11, 2'b11, 2'b11, 2'b11};
      mCnt = 0; mAddr = 0; mFirst = 0; mMatch = 0; mTx = 0;
      mPast = 0; mHold = 0; mArbPrev = 0;
    end else begin
      logic [1:0] c, p;
      bit st, sp, rise, fall, aDone, lsb, kill, comm, nMatch, nTx, nPast, nHold, nine;
      hist.push_back({scl, sda});
      c = hist[hist.size()-3];
      p = hist[hist.size()-4];
      void'(hist.pop_front());
      st   = p[1] && c[1] && p[0] && !c[0];
      sp   = p[1] && c[1] && !p[0] && c[0];
      rise = !p[1] && c[1];
      fall = p[1] && !c[1];
      lsb  = c[0];
      aDone = rise && mFirst && mCnt == 7;
      nine  = fall && mCnt == 9;
      kill  = !enable || sp || exitReq;
      nMatch = mMatch;
      if (kill || st) nMatch = 0;
      else if (aDone && !isMaster && mAddr == int'(localAddr)) nMatch = 1;
      comm = isMaster || extComm || nMatch;
      nTx = mTx;
      if (kill || waitRelease || (arbLost && !mArbPrev) || !comm) nTx = 0;
      else if (isMaster) begin
        if (startGen) nTx = 1; else if (aDone) nTx = !lsb;
      end else begin
        if (st) nTx = 0; else if (aDone) nTx = lsb;
      end
      nPast = mPast;
      if (kill || st) nPast = 0; else if (nine && mFirst) nPast = 1;
      nHold = mHold;
      if (kill || st || waitRelease || shiftWrite) nHold = 0;
      else if (nine && comm) nHold = 1;
      if (!enable || exitReq || sp) begin mCnt = 0; mFirst = 0; end
      else if (st) begin mCnt = 0; mFirst = 1; mAddr = 0; end
      else if (rise) begin
        if (mFirst && mCnt < 7) mAddr = ((mAddr << 1) | int'(lsb)) & 127;
        mCnt = (mCnt == 9) ? 1 : mCnt + 1;
      end else if (nine && mFirst) mFirst = 0;
      mMatch = nMatch; mTx = nTx; mPast = nPast; mHold = nHold;
      mArbPrev = arbLost;
    end
    #(CLK_PERIOD/4);
    if (rstN && !finished) begin
      chk("R3 per-clock addrMatch", addrMatch, mMatch);
      chk("R4 per-clock txState", txState, mTx);
      chk("R9 per-clock sdaDriveEn", sdaDriveEn, mTx && (isMaster || mPast));
      chk("R10 per-clock sclHold", sclHold, mHold);
    end
  end

  // ---------------- bus stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendStart();
    sda = 1'b1; idle(2);
    scl = 1'b1; idle(4);
    sda = 1'b0; idle(4);
    scl = 1'b0; idle(2);
  endtask

  task automatic sendStop();
    sda = 1'b0; idle(2);
    scl = 1'b1; idle(4);
    sda = 1'b1; idle(4);
  endtask

  task automatic sendBit(input logic b);
    sda = b;    idle(2);
    scl = 1'b1; idle(4);
    scl = 1'b0; idle(2);
  endtask

  task automatic sendAddr(input logic [ADDR_W-1:0] a, input logic rw);
    for (int i = ADDR_W - 1; i >= 0; i--) sendBit(a[i]);
    sendBit(rw);
    idle(4);
  endtask

  task automatic sendAck();
    sendBit(1'b0);
    idle(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R2 reset addrMatch", addrMatch, 1'b0);
    chk("R2 reset txState", txState, 1'b0);
    chk("R10 reset sclHold", sclHold, 1'b0);
    rstN = 1'b1; enable = 1'b1;
    idle(4);

    // Slave addressed for read
    sendStart(); sendAddr(7'h5A, 1'b1);
    chk("R3 match on own address", addrMatch, 1'b1);
    chk("R4 slave read gives transmit", txState, 1'b1);
    sendAck();
    chk("R9 slave drive after first ninth clock", sdaDriveEn, 1'b1);
    chk("R10 hold after ninth clock", sclHold, 1'b1);
    shiftWrite = 1'b1; idle(1); shiftWrite = 1'b0; idle(1);
    chk("R10 shift write releases hold", sclHold, 1'b0);
    chk("R10 shift write keeps transmit", txState, 1'b1);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    sendAck();
    chk("R10 hold after data byte", sclHold, 1'b1);
    waitRelease = 1'b1; idle(1); waitRelease = 1'b0; idle(1);
    chk("R8 release drops transmit", txState, 1'b0);
    chk("R8 release drops hold", sclHold, 1'b0);
    chk("R8 release tri-states SDA", sdaDriveEn, 1'b0);
    chk("R8 release keeps match", addrMatch, 1'b1);
    sendStart();
    chk("R2 start clears match", addrMatch, 1'b0);

    // Mismatched address, then extended communication
    sendAddr(7'h33, 1'b1);
    chk("R3 no match on other address", addrMatch, 1'b0);
    chk("R11 not addressed stays receive", txState, 1'b0);
    sendStop();
    extComm = 1'b1;
    sendStart(); sendAddr(7'h33, 1'b1);
    chk("R11 extended comm takes direction", txState, 1'b1);
    extComm = 1'b0; idle(2);
    chk("R11 leaving comm clears transmit", txState, 1'b0);
    sendStop();

    // Slave addressed for write
    sendStart(); sendAddr(7'h5A, 1'b0);
    chk("R4 slave write gives receive", txState, 1'b0);
    sendAck();
    chk("R10 hold while addressed", sclHold, 1'b1);
    chk("R9 no drive in receive", sdaDriveEn, 1'b0);
    waitRelease = 1'b1; idle(1); waitRelease = 1'b0; idle(1);
    chk("R8 release ends hold", sclHold, 1'b0);
    sendStop(); idle(2);
    chk("R2 stop clears match", addrMatch, 1'b0);

    // Master write then arbitration loss
    isMaster = 1'b1;
    startGen = 1'b1; idle(1); startGen = 1'b0; idle(1);
    chk("R5 start generation sets transmit", txState, 1'b1);
    chk("R9 master drives in transmit", sdaDriveEn, 1'b1);
    sendStart(); sendAddr(7'h5A, 1'b0);
    chk("R5 master write keeps transmit", txState, 1'b1);
    chk("R3 master never matches", addrMatch, 1'b0);
    sendAck();
    chk("R10 master hold", sclHold, 1'b1);
    arbLost = 1'b1; idle(2);
    chk("R6 arbitration loss clears transmit", txState, 1'b0);
    arbLost = 1'b0;
    shiftWrite = 1'b1; idle(1); shiftWrite = 1'b0; idle(1);
    sendStop();

    // Master read
    startGen = 1'b1; idle(1); startGen = 1'b0;
    sendStart(); sendAddr(7'h21, 1'b1);
    chk("R5 master read gives receive", txState, 1'b0);
    sendStop();
    isMaster = 1'b0;

    // Exit strobe
    sendStart(); sendAddr(7'h5A, 1'b1);
    exitReq = 1'b1; idle(1); exitReq = 1'b0; idle(1);
    chk("R6 exit clears match", addrMatch, 1'b0);
    chk("R6 exit clears transmit", txState, 1'b0);
    sendStop();

    // Disabled interface ignores the bus
    enable = 1'b0;
    sendStart(); sendAddr(7'h5A, 1'b1);
    chk("R7 disabled no match", addrMatch, 1'b0);
    chk("R7 disabled no transmit", txState, 1'b0);
    sendAck();
    chk("R7 disabled no hold", sclHold, 1'b0);
    sendStop();
    enable = 1'b1; idle(2);

    // Repeated start cuts a partial byte short
    sendStart(); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    sendStart(); sendAddr(7'h5A, 1'b1);
    chk("R1 restart recounts clocks", addrMatch, 1'b1);
    sendStop(); idle(4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule